// File: doc/BRIEF.md
# Cache Maintenance Command Engine

This block runs clean, invalidate and clean-then-invalidate operations on the tag, valid and dirty state of a 4-way set-associative data cache. Software sets up a physical address in one register, then writes a command word that holds an opcode and a way selection. The write itself starts the operation. Depending on the opcode, the engine works on the line that matches the address, on one set across the selected ways, or on every set of the selected ways.

Each line that needs cleaning, because it is valid and dirty, produces one writeback request. The request carries the line's address and stays up until the memory side acknowledges it. Only after that acknowledge is the dirty bit cleared. When the operation ends, the engine sets a done event bit. Software clears that bit by writing a one to a clear register. The event also reaches an interrupt output, gated by a mask register.

A fill port lets the refill logic install a line, giving it a tag, a set and a dirty state. Data storage and the processor hit path live elsewhere. With the default parameters the cache holds 32 KB in 32-byte lines, which is 256 sets of 4 ways.

Top module: `cme_engine`

## Requirements
- R1: Writing the command register at offset 0x04 starts an operation when the engine is idle. The opcode sits in bits 7:0 and the way bitmap in bits 11:8. Bit 0 of the busy register at offset 0x18 reads 1 from the cycle after the write until the operation ends.
- R2: Opcodes 1 (clean), 2 (invalidate) and 3 (clean then invalidate) take the address register at offset 0x00 and act on the way whose valid tag equals address bits 31:13, in the set given by address bits 12:5.
- R3: A clean of a valid, dirty line raises wb_req with the 32-byte aligned line address. wb_req and the address are held until wb_ack, and the dirty bit is then cleared, so a second clean of that line issues no request.
- R4: An invalidate clears the valid bit and issues no writeback. A clean-then-invalidate writes back a dirty line first and then clears its valid bit.
- R5: Opcodes 9, 10 and 11 apply clean, invalidate or both to the set given by address bits 12:5, in each way whose bitmap bit is 1.
- R6: Opcodes 17, 18 and 19 apply the same operations to every set of each selected way. Writebacks come out in ascending set order and, within a set, in ascending way order.
- R7: A command write that arrives while the engine is busy is ignored and changes no line.
- R8: A by-address operation that finds no matching line leaves all lines unchanged and still raises the done event.
- R9: The end of every operation sets bit 0 of the raw event register at offset 0x08. Writing 1 to bit 0 of offset 0x10 clears it. If a completion and a clear fall in the same cycle, the completion wins.
- R10: The status register at offset 0x14 reads the raw event ANDed with the mask register at offset 0x0C, and irq is high exactly when any status bit is set.
- R11: Opcode 0 and any opcode outside the nine listed above change no line and still raise the done event.
- R12: After reset the engine is idle, the raw event and mask are 0, wb_req is low and every line is invalid.
- R13: A fill pulse installs the tag from fill_addr into way fill_way of the set given by fill_addr bits 12:5. The line becomes valid, with its dirty bit taken from fill_dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked done event |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Line address of the writeback |
| wb_ack | input | 1 | Writeback acknowledge |
| fill_en | input | 1 | Install a line |
| fill_way | input | 2 | Way to install into |
| fill_addr | input | 32 | Address of the installed line |
| fill_dirty | input | 1 | Dirty state of the installed line |

## Verification
The hardest case to reach is a second command arriving while a walk is still running. If that command were accepted, its effect could only show up later, as a missing writeback. The stimulus starts a clean over the whole of way 0, which takes more than a thousand cycles. During that walk it writes an invalidate of way 1, then runs a clean by address on a dirty line held in way 1, which must still write back. Writeback order across a whole-way walk is compared request by request against a behavioural model, with the acknowledge delayed several cycles each time.

// File: rtl/cme_pkg.sv
package cme_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_VISIT,
        ST_WBWAIT,
        ST_FIN
    } seq_st_e;

    localparam logic [1:0] FAM_PA   = 2'd0;
    localparam logic [1:0] FAM_LINE = 2'd1;
    localparam logic [1:0] FAM_WAY  = 2'd2;

    localparam logic [7:0] OFS_ADDR = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_RAW  = 8'h08;
    localparam logic [7:0] OFS_MASK = 8'h0C;
    localparam logic [7:0] OFS_CLR  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_BUSY = 8'h18;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
    import cme_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              done,
    output logic              cmd_start,
    output logic [7:0]        cmd_opc,
    output logic [WAYS-1:0]   cmd_ways,
    output logic [ADDR_W-1:0] maint_addr,
    output logic              raw_evt,
    output logic              irq
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              mask;
        logic              raw;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr && reg_addr == OFS_ADDR) d.addr = reg_wdata[ADDR_W-1:0];
        if (reg_wr && reg_addr == OFS_MASK) d.mask = reg_wdata[0];
        if (reg_wr && reg_addr == OFS_CLR && reg_wdata[0]) d.raw = 1'b0;
        if (done) d.raw = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_start  = reg_wr && (reg_addr == OFS_CMD) && !busy;
    assign cmd_opc    = reg_wdata[7:0];
    assign cmd_ways   = reg_wdata[8 +: WAYS];
    assign maint_addr = q.addr;
    assign raw_evt    = q.raw;
    assign irq        = q.raw & q.mask;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ADDR: reg_rdata[ADDR_W-1:0] = q.addr;
            OFS_RAW:  reg_rdata[0] = q.raw;
            OFS_MASK: reg_rdata[0] = q.mask;
            OFS_STAT: reg_rdata[0] = q.raw & q.mask;
            OFS_BUSY: reg_rdata[0] = busy;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cme_tag_store.sv
module cme_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int TAG_W = 19,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    input  logic [WAYS-1:0]             mw_en,
    input  logic                        mw_valid,
    input  logic                        mw_dirty,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [IDX_W-1:0]            fill_set,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        fill_dirty
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             fill_hit;

        assign fill_hit = fill_en && (fill_way == WAY_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (mw_en[g]) begin
                valid_q[rd_set] <= mw_valid;
                dirty_q[rd_set] <= mw_dirty;
            end else if (fill_hit) begin
                valid_q[fill_set] <= 1'b1;
                dirty_q[fill_set] <= fill_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (!mw_en[g] && fill_hit) tag_q[fill_set] <= fill_tag;
        end

        assign rd_tag[g]   = tag_q[rd_set];
        assign rd_valid[g] = valid_q[rd_set];
        assign rd_dirty[g] = dirty_q[rd_set];
    end
endmodule

// File: rtl/cme_sequencer.sv
module cme_sequencer
    import cme_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 256,
    parameter int OFF_W  = 5,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_start,
    input  logic [7:0]                  cmd_opc,
    input  logic [WAYS-1:0]             cmd_ways,
    input  logic [ADDR_W-1:0]           maint_addr,
    output logic [IDX_W-1:0]            rd_set,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic [WAYS-1:0]             rd_valid,
    input  logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0]             mw_en,
    output logic                        mw_valid,
    output logic                        mw_dirty,
    output logic                        wb_req,
    output logic [ADDR_W-1:0]           wb_addr,
    input  logic                        wb_ack,
    output logic                        busy,
    output logic                        done
);
    typedef struct packed {
        seq_st_e          st;
        logic [7:0]       opc;
        logic [WAYS-1:0]  mask;
        logic [IDX_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic [TAG_W-1:0] tag;
    } seq_t;

    seq_t q, d;

    logic       op_clean, op_inv, legal, adv;
    logic [1:0] fam, new_fam;
    logic       cur_v, cur_d;
    logic [WAYS-1:0] hits;

    assign op_clean = q.opc[0];
    assign op_inv   = q.opc[1];
    assign fam      = q.opc[4:3];
    assign new_fam  = cmd_opc[4:3];
    assign legal    = (cmd_opc[7:5] == 3'd0) && !cmd_opc[2] &&
                      (cmd_opc[1:0] != 2'd0) && (new_fam != 2'd3);
    assign cur_v    = rd_valid[q.way];
    assign cur_d    = rd_dirty[q.way];
    assign rd_set   = q.set;

    always_comb begin
        for (int w = 0; w < WAYS; w++) hits[w] = rd_valid[w] && (rd_tag[w] == q.tag);
    end

    always_comb begin
        d        = q;
        adv      = 1'b0;
        mw_en    = '0;
        mw_valid = 1'b0;
        mw_dirty = 1'b0;
        wb_req   = 1'b0;
        done     = 1'b0;
        case (q.st)
            ST_IDLE: if (cmd_start) begin
                d.opc  = cmd_opc;
                d.mask = cmd_ways;
                d.tag  = maint_addr[ADDR_W-1 -: TAG_W];
                d.set  = (new_fam == FAM_WAY) ? '0 : maint_addr[OFF_W +: IDX_W];
                d.way  = '0;
                if (!legal)                 d.st = ST_FIN;
                else if (new_fam == FAM_PA) d.st = ST_LOOK;
                else                        d.st = ST_VISIT;
            end
            ST_LOOK: begin
                d.mask = hits;
                d.st   = ST_VISIT;
            end
            ST_VISIT: begin
                if (!q.mask[q.way]) begin
                    adv = 1'b1;
                end else if (cur_v && cur_d && op_clean) begin
                    d.st = ST_WBWAIT;
                end else begin
                    if (op_inv && cur_v) mw_en[q.way] = 1'b1;
                    mw_valid = 1'b0;
                    mw_dirty = 1'b0;
                    adv      = 1'b1;
                end
            end
            ST_WBWAIT: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    mw_en[q.way] = 1'b1;
                    mw_valid     = !op_inv;
                    mw_dirty     = 1'b0;
                    adv          = 1'b1;
                end
            end
            ST_FIN: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (adv) begin
            d.st = ST_VISIT;
            if (q.way == WAY_W'(WAYS - 1)) begin
                d.way = '0;
                if (fam == FAM_WAY && q.set != IDX_W'(SETS - 1)) d.set = q.set + 1'b1;
                else                                              d.st  = ST_FIN;
            end else begin
                d.way = q.way + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign wb_addr = {rd_tag[q.way], q.set, {OFF_W{1'b0}}};
endmodule

// File: rtl/cme_engine.sv
module cme_engine
    import cme_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 256,
    parameter int LINE_BYTES = 32,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty
);
    logic                       busy_w, done_w, raw_w, start_w;
    logic [7:0]                 opc_w;
    logic [WAYS-1:0]            ways_w;
    logic [ADDR_W-1:0]          maddr_w;
    logic [IDX_W-1:0]           rd_set_w;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag_w;
    logic [WAYS-1:0]            rd_valid_w, rd_dirty_w, mw_en_w;
    logic                       mw_valid_w, mw_dirty_w;

    cme_regs #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w), .done(done_w),
        .cmd_start(start_w), .cmd_opc(opc_w), .cmd_ways(ways_w),
        .maint_addr(maddr_w), .raw_evt(raw_w), .irq(irq)
    );

    cme_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(rd_set_w), .rd_tag(rd_tag_w),
        .rd_valid(rd_valid_w), .rd_dirty(rd_dirty_w), .mw_en(mw_en_w),
        .mw_valid(mw_valid_w), .mw_dirty(mw_dirty_w), .fill_en(fill_en),
        .fill_way(fill_way), .fill_set(fill_addr[OFF_W +: IDX_W]),
        .fill_tag(fill_addr[ADDR_W-1 -: TAG_W]), .fill_dirty(fill_dirty)
    );

    cme_sequencer #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .OFF_W(OFF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(start_w), .cmd_opc(opc_w),
        .cmd_ways(ways_w), .maint_addr(maddr_w), .rd_set(rd_set_w),
        .rd_tag(rd_tag_w), .rd_valid(rd_valid_w), .rd_dirty(rd_dirty_w),
        .mw_en(mw_en_w), .mw_valid(mw_valid_w), .mw_dirty(mw_dirty_w),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .busy(busy_w), .done(done_w)
    );
endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              busy,
    input logic              done,
    input logic              raw
);
    // R3
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req);
    // R3
    wb_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> $stable(wb_addr));
    // R3
    wb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> wb_addr[OFF_W-1:0] == '0);
    // R7
    wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy);
    // R9
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> raw);
    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr));
endmodule

bind cme_engine cme_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wb_req(wb_req), .wb_ack(wb_ack),
    .wb_addr(wb_addr), .busy(busy_w), .done(done_w), .raw(raw_w)
);

// File: tb/cme_engine_tb.sv
module cme_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, wb_req, wb_ack = 0;
    logic [31:0] wb_addr;
    logic        fill_en = 0, fill_dirty = 0;
    logic [1:0]  fill_way = 0;
    logic [31:0] fill_addr = 0;

    cme_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    bit m_v [4][256];
    bit m_d [4][256];
    int m_t [4][256];
    int exp_q[$];
    int wb_seen = 0, dly = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mk(input int tag, input int set);
        return (tag << 13) | (set << 5);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // per-clock comparison of the writeback stream against the model (R3, R6)
    always @(negedge clk) begin
        if (wb_ack) wb_ack = 0;
        else if (wb_req) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected writeback", wb_addr, 0);
                wb_ack = 1;
            end else if (dly == 2) begin
                check(wb_addr == exp_q[0], "R6 writeback address/order", wb_addr, exp_q[0]);
                void'(exp_q.pop_front());
                wb_seen++;
                wb_ack = 1;
                dly = 0;
            end else dly++;
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic fill(input int way, input int tag, input int set, input bit dirty);
        @(negedge clk);
        fill_en = 1; fill_way = way[1:0]; fill_addr = mk(tag, set); fill_dirty = dirty;
        @(negedge clk);
        fill_en = 0;
        m_v[way][set] = 1; m_d[way][set] = dirty; m_t[way][set] = tag;
    endtask

    function automatic void model_line(input int w, input int s, input bit cl, input bit inv);
        if (m_v[w][s] && m_d[w][s] && cl) begin
            exp_q.push_back(mk(m_t[w][s], s));
            m_d[w][s] = 0;
        end
        if (inv) begin m_v[w][s] = 0; m_d[w][s] = 0; end
    endfunction

    function automatic void model_exec(input int opc, input int ways, input int addr);
        int tag = (addr >> 13) & 32'h7FFFF;
        int set = (addr >> 5) & 8'hFF;
        bit cl  = opc[0];
        bit inv = opc[1];
        case (opc)
            1, 2, 3: for (int w = 0; w < 4; w++)
                if (m_v[w][set] && m_t[w][set] == tag) model_line(w, set, cl, inv);
            9, 10, 11: for (int w = 0; w < 4; w++)
                if (ways[w]) model_line(w, set, cl, inv);
            17, 18, 19: for (int s = 0; s < 256; s++)
                for (int w = 0; w < 4; w++) if (ways[w]) model_line(w, s, cl, inv);
            default: ;
        endcase
    endfunction

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        bus_read(cme_pkg::OFS_BUSY, v);
        while (v[0] && n < 5000) begin
            @(negedge clk); bus_read(cme_pkg::OFS_BUSY, v); n++;
        end
        check(v[0] == 0, req, v[0], 0);
    endtask

    task automatic run(input int opc, input int ways, input int addr, input string req, input int exp_wb);
        logic [31:0] v;
        bus_write(cme_pkg::OFS_ADDR, addr);
        model_exec(opc, ways, addr);
        wb_seen = 0;
        bus_write(cme_pkg::OFS_CMD, (ways << 8) | opc);
        bus_read(cme_pkg::OFS_BUSY, v);
        if (opc inside {1, 2, 3, 9, 10, 11, 17, 18, 19})
            check(v[0] == 1, "R1 busy during operation", v[0], 1);
        wait_idle(req);
        check(wb_seen == exp_wb, req, wb_seen, exp_wb);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        bus_read(cme_pkg::OFS_RAW, v);
        check(v[0] == 1, "R9 raw event set on completion", v[0], 1);
        bus_write(cme_pkg::OFS_CLR, 1);
        bus_read(cme_pkg::OFS_RAW, v);
        check(v[0] == 0, "R9 raw event cleared by write-one", v[0], 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        bus_read(cme_pkg::OFS_BUSY, v); check(v[0] == 0, "R12 busy after reset", v[0], 0);
        bus_read(cme_pkg::OFS_RAW, v);  check(v[0] == 0, "R12 raw after reset", v[0], 0);
        bus_read(cme_pkg::OFS_MASK, v); check(v[0] == 0, "R12 mask after reset", v[0], 0);
        check(wb_req == 0 && irq == 0, "R12 outputs after reset", {wb_req, irq}, 0);
        run(19, 4'hF, 0, "R12 all lines invalid: full flush gives no writeback", 0);

        // R13 install, R2/R3 clean by address
        fill(1, 19'h1234, 3, 1);
        run(1, 0, mk(19'h1234, 3), "R3 clean of dirty line", 1);
        run(1, 0, mk(19'h1234, 3), "R3 second clean issues nothing", 0);
        fill(2, 19'h0555, 3, 1);
        run(1, 0, mk(19'h0555, 3) | 5'h1C, "R2 by-address match ignores offset bits", 1);

        // R10 mask, status, irq
        bus_write(cme_pkg::OFS_MASK, 1);
        run(0, 0, 0, "R11 opcode 0 completes", 0);
        bus_write(cme_pkg::OFS_ADDR, 0);
        bus_write(cme_pkg::OFS_CMD, 0);
        @(negedge clk); @(negedge clk);
        bus_read(cme_pkg::OFS_STAT, v);
        check(v[0] == 1 && irq == 1, "R10 status and irq with mask set", {v[0], irq}, 3);
        bus_write(cme_pkg::OFS_MASK, 0);
        bus_read(cme_pkg::OFS_STAT, v);
        check(v[0] == 0 && irq == 0, "R10 status and irq masked off", {v[0], irq}, 0);
        bus_write(cme_pkg::OFS_CLR, 1);

        // R4 invalidate vs clean+invalidate
        fill(0, 19'h0AAA, 7, 1);
        run(2, 0, mk(19'h0AAA, 7), "R4 invalidate writes nothing back", 0);
        run(1, 0, mk(19'h0AAA, 7), "R4 invalidated line no longer cleans", 0);
        fill(3, 19'h0BBB, 9, 1);
        run(3, 0, mk(19'h0BBB, 9), "R4 clean+invalidate writes back", 1);
        fill(3, 19'h0BBB, 9, 0);
        run(1, 0, mk(19'h0BBB, 9), "R13 refilled clean line gives no writeback", 0);

        // R8 miss
        fill(0, 19'h0CCC, 11, 1);
        run(3, 0, mk(19'h0CCD, 11), "R8 miss leaves lines unchanged", 0);
        run(1, 0, mk(19'h0CCC, 11), "R8 line survives a miss", 1);

        // R11 unlisted opcode
        fill(1, 19'h0DDD, 12, 1);
        run(5, 4'hF, mk(19'h0DDD, 12), "R11 unlisted opcode changes nothing", 0);
        run(27, 4'hF, mk(19'h0DDD, 12), "R11 opcode 27 changes nothing", 0);
        run(1, 0, mk(19'h0DDD, 12), "R11 line intact after bad opcodes", 1);

        // R5 set/way line op with bitmap 0101
        fill(0, 19'h0100, 20, 1);
        fill(1, 19'h0101, 20, 1);
        fill(2, 19'h0102, 20, 1);
        run(9, 4'b0101, mk(0, 20), "R5 indexed clean on selected ways", 2);
        run(11, 4'hF, mk(0, 20), "R5 indexed flush of remaining way", 1);

        // R6 whole-way flush, ordering
        fill(3, 19'h0201, 0, 1);
        fill(1, 19'h0202, 0, 1);
        fill(2, 19'h0203, 100, 1);
        fill(0, 19'h0204, 255, 1);
        fill(2, 19'h0205, 255, 0);
        run(17, 4'b1011, 0, "R6 way clean over selected ways", 3);
        run(19, 4'hF, 0, "R6 way flush picks up unselected way", 1);
        run(17, 4'hF, 0, "R6 nothing left dirty", 0);

        // R7 command while busy is ignored
        fill(0, 19'h0301, 40, 1);
        fill(1, 19'h0302, 41, 1);
        bus_write(cme_pkg::OFS_ADDR, 0);
        model_exec(17, 4'b0001, 0);
        wb_seen = 0;
        bus_write(cme_pkg::OFS_CMD, (4'b0001 << 8) | 17);
        bus_write(cme_pkg::OFS_CMD, (4'b0010 << 8) | 18);
        wait_idle("R7 busy walk finishes");
        check(wb_seen == 1, "R7 first walk wrote back", wb_seen, 1);
        bus_write(cme_pkg::OFS_CLR, 1);
        run(1, 0, mk(19'h0302, 41), "R7 ignored invalidate left line", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule